// File: doc/BRIEF.md
# Parallel converter sampling controller

This block sits on the host side of a 12-bit analog-to-digital converter that has a parallel output bus and a four-wire handshake. The four wires are an active-low start line, a BUSY flag from the converter, an active-low chip-select and an active-low read strobe. A conversion begins on a host request pulse, or on an internal tick at a programmable clock count. The block drives the start line low for a fixed number of clocks and waits for BUSY to go high and then low again. It then drops chip-select and read together and latches the bus one clock later. The latched word is presented on a data output with a one-cycle valid pulse.

The block keeps the converter inside its timing rules. The start line is back high well before BUSY can fall. No read strobe is issued while BUSY is high. A new start is held off until a configurable settling time has passed since BUSY fell. After reset it runs one conversion by itself and drops that result. A configuration input holds chip-select low permanently, so that the read strobe alone gates the bus. Two watchdog counters raise a one-cycle error pulse when BUSY fails to rise after a start, or fails to fall after rising. The sequence then returns to idle.

Top module: `adc_host_ctrl`

## Requirements
- R1: While rst_ni is low, convst_no, cs_no and rd_no are high, and smp_valid_o and err_o are low.
- R2: After reset, one conversion starts without any request, and its result never raises smp_valid_o.
- R3: A request drives convst_no low for exactly START_CYC clocks. convst_no is high again before BUSY falls, and it never falls while BUSY is high.
- R4: rd_no is never low while BUSY is high. When cs_tied_i is 0, cs_no and rd_no move together.
- R5: Each non-dummy conversion gives exactly one single-cycle smp_valid_o pulse, with smp_data_o equal to the value the bus held while both strobes were low.
- R6: A falling edge on convst_no comes no sooner than ceil(QUIET_NS/CLK_NS) clocks after BUSY fell.
- R7: With auto_en_i at 1 and period_i at P, and P longer than a full conversion cycle, conversions start exactly P clocks apart.
- R8: With cs_tied_i at 1, cs_no stays low, and reads still return correct data.
- R9: If BUSY does not rise within RISE_TMO clocks after the start pulse ends, err_o pulses for one cycle, no sample is presented, and the block returns to idle.
- R10: If BUSY stays high for FALL_TMO clocks, err_o pulses for one cycle, no sample is presented, and later requests are served normally.
- R11: A request that arrives while a conversion is in flight is held and served once the current one ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | One-cycle conversion request |
| auto_en_i | input | 1 | Enables periodic conversions |
| period_i | input | PW | Clocks between periodic starts |
| cs_tied_i | input | 1 | 1: chip-select held low, read strobe alone gates the bus |
| busy_i | input | 1 | Converter BUSY flag (asynchronous) |
| data_i | input | DW | Converter parallel data bus |
| convst_no | output | 1 | Start line to converter, active low |
| cs_no | output | 1 | Chip-select, active low |
| rd_no | output | 1 | Read strobe, active low |
| smp_valid_o | output | 1 | One-cycle pulse for a new sample |
| smp_data_o | output | DW | Latched sample |
| err_o | output | 1 | One-cycle pulse on a BUSY timeout |

## Verification
If the sequencer loses track of the dummy flag, a valid pulse appears within one clock of the first read after reset, or a real sample goes missing. If the settling or start-width counters are wrong, the next falling edge on the start line is early or late. The converter model measures that spacing in clocks on every start. A stale synchronizer or wrong state decode shows up as a read strobe during BUSY, or as a latched word that differs from the bus value. Both are detected in the same cycle. A broken watchdog shows up as a missing error pulse within a few clocks of the timeout limit.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_WAIT_RISE,
    ST_WAIT_FALL,
    ST_READ
  } ctl_state_e;
endpackage

// File: rtl/busy_sync.sv
module busy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  output logic busy_s_o,
  output logic fall_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], busy_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign busy_s_o = sh_q[STAGES-1];
  assign fall_o   = prev_q & ~sh_q[STAGES-1];
endmodule

// File: rtl/rate_tick.sv
module rate_tick #(
  parameter int PW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [PW-1:0] period_i,
  output logic          tick_o
);
  logic [PW-1:0] cnt_q;
  logic          last;

  assign last   = (period_i <= PW'(1)) || (cnt_q >= period_i - PW'(1));
  assign tick_o = en_i & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!en_i)     cnt_q <= '0;
    else if (last)      cnt_q <= '0;
    else                cnt_q <= cnt_q + PW'(1);
  end
endmodule

// File: rtl/down_timer.sv
module down_timer #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - TW'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/adc_host_ctrl.sv
module adc_host_ctrl
  import adc_host_pkg::*;
#(
  parameter int DW        = 12,
  parameter int PW        = 16,
  parameter int CLK_NS    = 10,
  parameter int QUIET_NS  = 140,
  parameter int START_CYC = 3,
  parameter int RISE_TMO  = 16,
  parameter int FALL_TMO  = 4096,
  parameter int SYNC_STG  = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          auto_en_i,
  input  logic [PW-1:0] period_i,
  input  logic          cs_tied_i,
  input  logic          busy_i,
  input  logic [DW-1:0] data_i,
  output logic          convst_no,
  output logic          cs_no,
  output logic          rd_no,
  output logic          smp_valid_o,
  output logic [DW-1:0] smp_data_o,
  output logic          err_o
);
  localparam int QUIET_CYC = (QUIET_NS + CLK_NS - 1) / CLK_NS;
  localparam int QW        = $clog2(QUIET_CYC + 1);
  localparam int MAX_A     = (RISE_TMO > FALL_TMO) ? RISE_TMO : FALL_TMO;
  localparam int MAX_T     = (MAX_A > START_CYC) ? MAX_A : START_CYC;
  localparam int TW        = $clog2(MAX_T + 1);

  ctl_state_e state_q, state_d;
  logic busy_s, busy_fall, tick;
  logic tmr_load, tmr_zero, q_load, q_zero;
  logic [TW-1:0] tmr_val;
  logic pend_q, dummy_q, start_real, cap, err_d;

  busy_sync #(.STAGES(SYNC_STG)) i_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy_i),
    .busy_s_o(busy_s), .fall_o(busy_fall)
  );

  rate_tick #(.PW(PW)) i_rate (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(auto_en_i),
    .period_i(period_i), .tick_o(tick)
  );

  down_timer #(.TW(TW)) i_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load),
    .val_i(tmr_val), .zero_o(tmr_zero)
  );

  down_timer #(.TW(QW)) i_quiet (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(q_load),
    .val_i(QW'(QUIET_CYC)), .zero_o(q_zero)
  );

  always_comb begin
    state_d    = state_q;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    q_load     = 1'b0;
    cap        = 1'b0;
    err_d      = 1'b0;
    start_real = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (q_zero && (dummy_q || pend_q)) begin
          state_d    = ST_START;
          tmr_load   = 1'b1;
          tmr_val    = TW'(START_CYC - 1);
          start_real = ~dummy_q;
        end
      end
      ST_START: begin
        if (tmr_zero) begin
          state_d  = ST_WAIT_RISE;
          tmr_load = 1'b1;
          tmr_val  = TW'(RISE_TMO);
        end
      end
      ST_WAIT_RISE: begin
        if (busy_s) begin
          state_d  = ST_WAIT_FALL;
          tmr_load = 1'b1;
          tmr_val  = TW'(FALL_TMO);
        end else if (tmr_zero) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
          q_load  = 1'b1;
        end
      end
      ST_WAIT_FALL: begin
        if (busy_fall) begin
          state_d = ST_READ;
          q_load  = 1'b1;
        end else if (tmr_zero) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
          q_load  = 1'b1;
        end
      end
      ST_READ: begin
        cap     = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      pend_q      <= 1'b0;
      dummy_q     <= 1'b1;
      smp_valid_o <= 1'b0;
      smp_data_o  <= '0;
      err_o       <= 1'b0;
    end else begin
      state_q     <= state_d;
      pend_q      <= (pend_q & ~start_real) | req_i | tick;
      smp_valid_o <= cap & ~dummy_q;
      err_o       <= err_d;
      if (cap) begin
        smp_data_o <= data_i;
        dummy_q    <= 1'b0;
      end
    end
  end

  assign convst_no = (state_q != ST_START);
  assign rd_no     = (state_q != ST_READ);
  assign cs_no     = cs_tied_i ? 1'b0 : rd_no;

  a_r4_no_read_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> !busy_s);
  a_r3_start_high_at_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_fall |-> convst_no);
  a_r5_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o |=> !smp_valid_o);
  a_r5_valid_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o |-> $past(!rd_no));
  a_r9_err_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);
  a_r8_cs_tied: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_tied_i && $stable(cs_tied_i)) |-> !cs_no);
endmodule

// File: tb/test_adc_host_ctrl.sv
module test_adc_host_ctrl;
  localparam int CLK_NS    = 10;
  localparam int QUIET_CYC = 14;
  localparam int START_CYC = 3;
  localparam int RISE_TMO  = 16;
  localparam int FALL_TMO  = 300;

  logic clk = 0, rst_n = 0, req = 0, auto_en = 0, cs_tied = 0;
  logic [15:0] period = 16'd100;
  logic busy = 0;
  logic [11:0] data_bus, last_val = 12'h0, conv_val = 12'h0;
  logic convst_n, cs_n, rd_n, valid, err;
  logic [11:0] smp;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int starts = 0, conv_n = 0, valids = 0, errs = 0;
  int last_start = 0, prev_start = 0, last_fall = -1000;
  int low_len = 0, last_low_len = 0, rise_dly = 0, busy_cnt = 0, conv_len = 30;
  int viol_restart = 0, viol_quiet = 0, viol_rd = 0, viol_cs = 0, viol_tie = 0;
  bit mute = 0, stuck = 0, prev_valid = 0, convst_q = 1;

  adc_host_ctrl #(.CLK_NS(CLK_NS), .QUIET_NS(140), .START_CYC(START_CYC),
                  .RISE_TMO(RISE_TMO), .FALL_TMO(FALL_TMO)) i_adc_host_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .auto_en_i(auto_en),
    .period_i(period), .cs_tied_i(cs_tied), .busy_i(busy), .data_i(data_bus),
    .convst_no(convst_n), .cs_no(cs_n), .rd_no(rd_n), .smp_valid_o(valid),
    .smp_data_o(smp), .err_o(err)
  );

  always #(CLK_NS/2) clk = ~clk;

  assign data_bus = (!cs_n && !rd_n) ? last_val : 12'hA5A;

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  // behavioural converter model
  always @(posedge clk) begin
    cyc++;
    if (!convst_n) low_len++;
    if (convst_q && !convst_n) begin
      if (busy) viol_restart++;
      if (cyc - last_fall < QUIET_CYC) viol_quiet++;
      prev_start = last_start;
      last_start = cyc;
      starts++;
      low_len = 1;
      if (!mute) rise_dly = 2;
    end
    if (!convst_q && convst_n) last_low_len = low_len;
    convst_q = convst_n;
    if (rst_n) begin
      if (!rd_n && busy) viol_rd++;
      if (!cs_tied && (cs_n != rd_n)) viol_cs++;
      if (cs_tied && cs_n) viol_tie++;
    end
    if (rise_dly > 0) begin
      rise_dly--;
      if (rise_dly == 0) begin
        busy <= 1'b1;
        busy_cnt = conv_len;
        conv_val = 12'($urandom);
      end
    end else if (busy && !stuck) begin
      busy_cnt--;
      if (busy_cnt <= 0) begin
        busy <= 1'b0;
        last_val <= conv_val;
        last_fall = cyc;
        conv_n++;
      end
    end
  end

  // output monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (valid) begin
        valids++;
        chk(smp == last_val, "R5", smp, last_val);
        if (prev_valid) chk(0, "R5", 1, 0);
      end
      if (err) errs++;
    end
    prev_valid = valid;
  end

  task automatic do_req();
    @(negedge clk) req = 1;
    @(negedge clk) req = 0;
  endtask

  task automatic wait_start();
    int s = starts;
    while (starts == s) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unsigned sd = $urandom(32'd4711);
    int v0, e0, s0;
    if (sd == 0) sd = 1;
    // R1 reset values
    repeat (3) @(negedge clk);
    chk(convst_n == 1, "R1", convst_n, 1);
    chk(cs_n == 1, "R1", cs_n, 1);
    chk(rd_n == 1, "R1", rd_n, 1);
    chk(valid == 0 && err == 0, "R1", {valid, err}, 0);
    rst_n = 1;
    // R2 dummy conversion
    repeat (150) @(negedge clk);
    chk(conv_n == 1, "R2", conv_n, 1);
    chk(valids == 0, "R2", valids, 0);
    // R3 directed request
    v0 = valids;
    do_req();
    repeat (120) @(negedge clk);
    chk(valids == v0 + 1, "R3", valids, v0 + 1);
    chk(last_low_len == START_CYC, "R3", last_low_len, START_CYC);
    // random requests, R5 R6
    for (int i = 0; i < 25; i++) begin
      conv_len = 20 + int'($urandom % 21);
      do_req();
      repeat (1 + $urandom % 140) @(negedge clk);
    end
    repeat (300) @(negedge clk);
    chk(valids == conv_n - 1, "R5", valids, conv_n - 1);
    // R11 request during conversion
    s0 = starts;
    conv_len = 30;
    do_req();
    repeat (10) @(negedge clk);
    do_req();
    repeat (250) @(negedge clk);
    chk(starts == s0 + 2, "R11", starts, s0 + 2);
    // R7 periodic mode, two periods
    for (int p = 0; p < 2; p++) begin
      period = (p == 0) ? 16'd120 : 16'(80 + $urandom % 60);
      auto_en = 1;
      repeat (2) wait_start();
      for (int k = 0; k < 3; k++) begin
        wait_start();
        chk(last_start - prev_start == int'(period), "R7",
            last_start - prev_start, period);
      end
      auto_en = 0;
      repeat (200) @(negedge clk);
    end
    // R8 chip-select tied low
    cs_tied = 1;
    v0 = valids;
    for (int i = 0; i < 5; i++) begin
      do_req();
      repeat (120) @(negedge clk);
    end
    chk(valids == v0 + 5, "R8", valids, v0 + 5);
    chk(viol_tie == 0, "R8", viol_tie, 0);
    cs_tied = 0;
    // R9 BUSY never rises
    mute = 1;
    e0 = errs; v0 = valids;
    do_req();
    repeat (40) @(negedge clk);
    chk(errs == e0 + 1, "R9", errs, e0 + 1);
    chk(valids == v0, "R9", valids, v0);
    chk(convst_n && rd_n, "R9", {convst_n, rd_n}, 3);
    mute = 0;
    repeat (30) @(negedge clk);
    // R10 BUSY stuck high
    stuck = 1;
    e0 = errs; v0 = valids;
    do_req();
    repeat (FALL_TMO + 40) @(negedge clk);
    chk(errs == e0 + 1, "R10", errs, e0 + 1);
    chk(valids == v0, "R10", valids, v0);
    stuck = 0;
    repeat (50) @(negedge clk);
    do_req();
    repeat (120) @(negedge clk);
    chk(valids == v0 + 1, "R10", valids, v0 + 1);
    // protocol rule counters
    chk(viol_restart == 0, "R3", viol_restart, 0);
    chk(viol_rd == 0, "R4", viol_rd, 0);
    chk(viol_cs == 0, "R4", viol_cs, 0);
    chk(viol_quiet == 0, "R6", viol_quiet, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule